// File: doc/BRIEF.md
# Chip Erase Retry Sequencer

This block runs a complete electrical chip erase on an external byte-wide erasable memory, working as the host that controls it. A single-cycle `start` request sets it going. It first sends the two-command erase entry. The first command writes AA to address 5555 hex with a short latch pulse. The second command writes 10 to address 2AAA hex with a much longer latch pulse. For both commands the high-voltage request is asserted.

The block then reads the array back in erase-verify mode, one location at a time, starting at address zero and counting up to the last address. Every byte must read FF. If a byte does not read FF, the block repeats the whole erase and starts a new verify from address zero. The number of failed verify passes is capped by a retry limit. When the run ends, the block shows the result on sticky `pass` and `fail` outputs, together with a single-cycle `done` pulse.

All timings are parameters counted in clock cycles: command setup, the two pulse widths, hold, address latch and read delay. This lets a scaled-down simulation share the RTL with a build at the real clock rate. Supply sequencing and the analog drivers are handled outside this block.

Top module: `erase_seq`

## Requirements
- R1: After reset the outputs are `ale`=0, `hv_req`=0, `oe_n`=1, `data_oe`=0, `busy`=0, `done`=0, `pass`=0, `fail`=0.
- R2: The first command drives `addr`=16'h5555 and `dout`=8'hAA with `data_oe`=1 and `hv_req`=1 for SETUP_CYC+CMD1_PULSE+HOLD_CYC cycles. Within that window `ale` is high for exactly CMD1_PULSE cycles, after SETUP_CYC low cycles.
- R3: The second command follows at once with `addr`=16'h2AAA and `dout`=8'h10 and the same framing. Its `ale` pulse lasts CMD2_PULSE cycles.
- R4: `oe_n` is never low while `hv_req` or `data_oe` is high.
- R5: Verify presents the addresses 0, 1, 2 … in ascending order. No address is above LAST_ADDR. Each address is latched with `ale` high for LATCH_CYC cycles while `oe_n`=1 and `hv_req`=0.
- R6: After the latch, `oe_n` stays low for READ_DLY cycles. `din` is sampled in the last of those cycles. One check cycle with `oe_n`=1 follows, and a byte other than 8'hFF ends the current verify pass.
- R7: A failed verify pass costs one idle retry cycle and then restarts from the first command. After MAX_RETRY failed passes, `fail` is set.
- R8: If every byte up to LAST_ADDR reads 8'hFF, `pass` is set. `done` is high for exactly one cycle, and it is the cycle in which `pass` or `fail` first appears.
- R9: `pass` and `fail` are never high together. Each holds its value until a new `start` is accepted, which clears both. A `start` seen while `busy`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase run; accepted only when idle |
| din | input | 8 | Byte read from the memory during verify |
| ale | output | 1 | Address latch / command pulse to the memory |
| hv_req | output | 1 | Request for high voltage on the memory's enable pin |
| oe_n | output | 1 | Memory output enable, active low (verify reads) |
| data_oe | output | 1 | Controller drives `dout` onto the data bus |
| addr | output | 16 | Memory address |
| dout | output | 8 | Command data byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Sticky: the last run verified blank |
| fail | output | 1 | Sticky: the last run ran out of retries |

## Verification
Some properties are checked on every clock cycle. The bus never has an output-enable overlapping a driven bus or the high-voltage request. `pass` and `fail` are exclusive and hold their values. Verify addresses only step upward by one and stay within range, the command address and data are stable when `ale` rises, and the retry count stays below its limit. Other behaviour can only be shown by the bench's scenarios, in which a modelled memory clears a faulty byte only after a chosen number of erases. These scenarios cover the exact pulse lengths, the read-sample point, restart from address zero after a retry, exhaustion of the retry limit, a fault at the last address, and a `start` that arrives mid-run.

// File: rtl/erase_seq_pkg.sv
`timescale 1ns/1ps
package erase_seq_pkg;
  localparam int BUS_AW = 16;
  localparam int BUS_DW = 8;

  localparam logic [BUS_AW-1:0] UNLOCK_ADDR = 16'h5555;
  localparam logic [BUS_DW-1:0] UNLOCK_DATA = 8'hAA;
  localparam logic [BUS_AW-1:0] ERASE_ADDR  = 16'h2AAA;
  localparam logic [BUS_DW-1:0] ERASE_DATA  = 8'h10;
  localparam logic [BUS_DW-1:0] BLANK_BYTE  = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_CMD2, S_VADDR, S_VREAD, S_CHECK, S_RETRY, S_DONE
  } seq_state_e;
endpackage

// File: rtl/erase_seq_timer.sv
`timescale 1ns/1ps
module erase_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/erase_seq_addr.sv
`timescale 1ns/1ps
module erase_seq_addr
  import erase_seq_pkg::*;
#(
  parameter logic [BUS_AW-1:0] LAST_ADDR = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [BUS_AW-1:0] addr,
  output logic              is_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (clr)  addr <= '0;
    else if (inc)  addr <= addr + 1'b1;
  end

  assign is_last = (addr == LAST_ADDR);

  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= LAST_ADDR);
endmodule

// File: rtl/erase_seq.sv
`timescale 1ns/1ps
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int SETUP_CYC  = 100,
  parameter int CMD1_PULSE = 2500,
  parameter int CMD2_PULSE = 5000000,
  parameter int HOLD_CYC   = 100,
  parameter int LATCH_CYC  = 5,
  parameter int READ_DLY   = 8,
  parameter int MAX_RETRY  = 20,
  parameter logic [15:0] LAST_ADDR = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  din,
  output logic        ale,
  output logic        hv_req,
  output logic        oe_n,
  output logic        data_oe,
  output logic [15:0] addr,
  output logic [7:0]  dout,
  output logic        busy,
  output logic        done,
  output logic        pass,
  output logic        fail
);
  localparam int CMD1_LEN = SETUP_CYC + CMD1_PULSE + HOLD_CYC;
  localparam int CMD2_LEN = SETUP_CYC + CMD2_PULSE + HOLD_CYC;
  localparam int LONG_A   = (CMD1_LEN > CMD2_LEN) ? CMD1_LEN : CMD2_LEN;
  localparam int LONG_B   = (LATCH_CYC > READ_DLY) ? LATCH_CYC : READ_DLY;
  localparam int LONGEST  = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int TW       = $clog2(LONGEST + 1);
  localparam int RW       = $clog2(MAX_RETRY + 1);

  localparam logic [TW-1:0] C1_END   = TW'(CMD1_LEN - 1);
  localparam logic [TW-1:0] C2_END   = TW'(CMD2_LEN - 1);
  localparam logic [TW-1:0] LAT_END  = TW'(LATCH_CYC - 1);
  localparam logic [TW-1:0] RD_END   = TW'(READ_DLY - 1);
  localparam logic [TW-1:0] PUL_LO   = TW'(SETUP_CYC);
  localparam logic [TW-1:0] C1_PUL_HI = TW'(SETUP_CYC + CMD1_PULSE);
  localparam logic [TW-1:0] C2_PUL_HI = TW'(SETUP_CYC + CMD2_PULSE);
  localparam logic [RW-1:0] RETRY_LAST = RW'(MAX_RETRY - 1);

  seq_state_e        state, state_d;
  logic [TW-1:0]     cnt;
  logic              tmr_clr;
  logic [BUS_AW-1:0] vaddr;
  logic              vaddr_last, vaddr_clr, vaddr_inc;
  logic [RW-1:0]     retry_q;
  logic [7:0]        rd_byte;
  logic              accept, byte_ok, retry_final;

  assign accept      = (state == S_IDLE) && start;
  assign byte_ok     = (rd_byte == BLANK_BYTE);
  assign retry_final = (retry_q == RETRY_LAST);

  // sequencing
  always_comb begin
    state_d = state;
    unique case (state)
      S_IDLE:  if (start) state_d = S_CMD1;
      S_CMD1:  if (cnt == C1_END) state_d = S_CMD2;
      S_CMD2:  if (cnt == C2_END) state_d = S_VADDR;
      S_VADDR: if (cnt == LAT_END) state_d = S_VREAD;
      S_VREAD: if (cnt == RD_END) state_d = S_CHECK;
      S_CHECK: begin
        if (!byte_ok)        state_d = S_RETRY;
        else if (vaddr_last) state_d = S_DONE;
        else                 state_d = S_VADDR;
      end
      S_RETRY: state_d = retry_final ? S_DONE : S_CMD1;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_d;
  end

  assign tmr_clr = (state_d != state) || (state == S_IDLE);

  erase_seq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(cnt)
  );

  assign vaddr_clr = accept || (state == S_RETRY);
  assign vaddr_inc = (state == S_CHECK) && byte_ok && !vaddr_last;

  erase_seq_addr #(.LAST_ADDR(LAST_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(vaddr_clr), .inc(vaddr_inc),
    .addr(vaddr), .is_last(vaddr_last)
  );

  // retry counter, read capture, result flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_q <= '0;
      rd_byte <= '0;
      pass    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      if (accept) begin
        retry_q <= '0;
        pass    <= 1'b0;
        fail    <= 1'b0;
      end
      if (state == S_VREAD && cnt == RD_END) rd_byte <= din;
      if (state == S_CHECK && byte_ok && vaddr_last) pass <= 1'b1;
      if (state == S_RETRY) begin
        if (retry_final) fail <= 1'b1;
        else             retry_q <= retry_q + 1'b1;
      end
    end
  end

  // bus drive
  always_comb begin
    ale     = 1'b0;
    hv_req  = 1'b0;
    oe_n    = 1'b1;
    data_oe = 1'b0;
    addr    = '0;
    dout    = '0;
    unique case (state)
      S_CMD1: begin
        hv_req = 1'b1; data_oe = 1'b1;
        addr = UNLOCK_ADDR; dout = UNLOCK_DATA;
        ale = (cnt >= PUL_LO) && (cnt < C1_PUL_HI);
      end
      S_CMD2: begin
        hv_req = 1'b1; data_oe = 1'b1;
        addr = ERASE_ADDR; dout = ERASE_DATA;
        ale = (cnt >= PUL_LO) && (cnt < C2_PUL_HI);
      end
      S_VADDR: begin ale = 1'b1; addr = vaddr; end
      S_VREAD: begin oe_n = 1'b0; addr = vaddr; end
      S_CHECK: addr = vaddr;
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !hv_req && !data_oe);
  assert_cmd_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) && hv_req |-> $stable(addr) && $stable(dout));
  assert_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VADDR) && ($past(state) == S_CHECK) |-> addr == 16'($past(addr) + 16'd1));
  assert_sample_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CHECK |-> $past(state) == S_VREAD && !$past(oe_n));
  assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q < RW'(MAX_RETRY));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pass && !accept |=> pass);
endmodule

// File: tb/erase_seq_tb.sv
`timescale 1ns/1ps
module erase_seq_tb;
  localparam int SETUP = 2, P1 = 3, P2 = 9, HOLD = 2, LATCH = 2, RDLY = 3;
  localparam int MAXR = 3;
  localparam int LAST = 15;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] din;
  logic ale, hv_req, oe_n, data_oe, busy, done, pass, fail;
  logic [15:0] addr;
  logic [7:0] dout;

  always #10 clk = ~clk;

  erase_seq #(
    .SETUP_CYC(SETUP), .CMD1_PULSE(P1), .CMD2_PULSE(P2), .HOLD_CYC(HOLD),
    .LATCH_CYC(LATCH), .READ_DLY(RDLY), .MAX_RETRY(MAXR), .LAST_ADDR(16'(LAST))
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .ale(ale),
    .hv_req(hv_req), .oe_n(oe_n), .data_oe(data_oe), .addr(addr), .dout(dout),
    .busy(busy), .done(done), .pass(pass), .fail(fail)
  );

  // memory model: a faulty byte clears only after clear_after complete erases
  logic [15:0] mem_lat = '0;
  int erase_count = 0, clear_after = 1, bad_addr = 0;
  bit armed = 0;
  always @(negedge ale) begin
    mem_lat = addr;
    if (hv_req && data_oe) begin
      if (addr == 16'h5555 && dout == 8'hAA) armed = 1;
      else if (armed && addr == 16'h2AAA && dout == 8'h10) begin
        erase_count++; armed = 0;
      end else armed = 0;
    end
  end
  always_comb begin
    din = 8'h00;
    if (!oe_n) din = (int'(mem_lat) == bad_addr && erase_count < clear_after) ? 8'hEF : 8'hFF;
  end

  function automatic bit byte_bad(int a);
    return (a == bad_addr) && (erase_count < clear_after);
  endfunction

  int n_chk = 0, n_fail = 0, cyc = 0, poke_at = -1;
  bit cmp_on = 0, finished = 0;
  logic e_ale, e_hv, e_oen, e_doe, e_bz, e_dn, e_ps, e_fl;
  logic [15:0] e_addr;
  logic [7:0] e_dout;
  string e_req = "R1";

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the reference model
  always @(negedge clk) if (cmp_on) begin
    check(ale == e_ale && addr == e_addr && dout == e_dout, e_req, "ale/addr/dout",
          {ale, addr, dout}, {e_ale, e_addr, e_dout});
    // R4 bus direction and high-voltage request
    check(hv_req == e_hv && oe_n == e_oen && data_oe == e_doe, {e_req, "/R4"}, "hv/oe_n/data_oe",
          {hv_req, oe_n, data_oe}, {e_hv, e_oen, e_doe});
    check(busy == e_bz && done == e_dn && pass == e_ps && fail == e_fl, {e_req, "/R9"},
          "busy/done/pass/fail", {busy, done, pass, fail}, {e_bz, e_dn, e_ps, e_fl});
  end

  task automatic set_idle(input logic ps, input logic fl);
    e_ale = 0; e_hv = 0; e_oen = 1; e_doe = 0; e_addr = 0; e_dout = 0;
    e_bz = 0; e_dn = 0; e_ps = ps; e_fl = fl; e_req = "R9";
  endtask

  task automatic step(input logic a, input logic hv, input logic oen, input logic doe,
                      input int ad, input int dt, input logic dn, input logic ps,
                      input logic fl, input string rq);
    e_ale = a; e_hv = hv; e_oen = oen; e_doe = doe; e_addr = 16'(ad); e_dout = 8'(dt);
    e_bz = 1; e_dn = dn; e_ps = ps; e_fl = fl; e_req = rq;
    start = (cyc == poke_at);
    cyc++;
    @(posedge clk); #1;
  endtask

  task automatic run_job(input bit exp_pass);
    int tries = 0;
    bit ok;
    bit result_pass = 0;
    start = 1;
    @(posedge clk); #1;
    start = 0; cyc = 0;
    check(!pass && !fail && busy, "R9", "flags clear on accept", {pass, fail, busy}, 3'b001);
    forever begin
      for (int c = 0; c < SETUP + P1 + HOLD; c++)
        step(c >= SETUP && c < SETUP + P1, 1, 1, 1, 16'h5555, 8'hAA, 0, 0, 0, "R2");
      for (int c = 0; c < SETUP + P2 + HOLD; c++)
        step(c >= SETUP && c < SETUP + P2, 1, 1, 1, 16'h2AAA, 8'h10, 0, 0, 0, "R3");
      ok = 1;
      for (int a = 0; a <= LAST; a++) begin
        for (int c = 0; c < LATCH; c++) step(1, 0, 1, 0, a, 0, 0, 0, 0, "R5");
        for (int c = 0; c < RDLY; c++)  step(0, 0, 0, 0, a, 0, 0, 0, 0, "R6");
        step(0, 0, 1, 0, a, 0, 0, 0, 0, "R6");
        if (byte_bad(a)) begin ok = 0; break; end
      end
      if (ok) begin
        step(0, 0, 1, 0, 0, 0, 1, 1, 0, "R8");
        result_pass = 1;
        break;
      end
      step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
      tries++;
      if (tries == MAXR) begin
        step(0, 0, 1, 0, 0, 0, 1, 0, 1, "R7");
        break;
      end
    end
    set_idle(result_pass, !result_pass);
    repeat (3) @(posedge clk);
    #1;
    if (exp_pass) check(pass && !fail, "R8", "pass result", {pass, fail}, 2'b10);
    else          check(fail && !pass, "R7", "fail result", {pass, fail}, 2'b01);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    set_idle(0, 0);
    e_req = "R1";
    repeat (3) @(posedge clk);
    #1;
    check(!ale && !hv_req && oe_n && !data_oe && !busy && !done && !pass && !fail,
          "R1", "reset outputs", {ale, hv_req, oe_n, data_oe, busy, done, pass, fail}, 8'b0010_0000);
    rst_n = 1;
    @(posedge clk); #1;
    cmp_on = 1;
    @(posedge clk); #1;

    // R8: blank after first erase
    erase_count = 0; clear_after = 1; bad_addr = 3; poke_at = -1;
    run_job(1);
    // R7 one retry, R9 start while busy ignored
    erase_count = 0; clear_after = 2; bad_addr = 7; poke_at = 5;
    run_job(1);
    // R7 retries exhausted
    erase_count = 0; clear_after = 99; bad_addr = 0; poke_at = -1;
    run_job(0);
    // R5 fault at the last address, passes on the final allowed attempt
    erase_count = 0; clear_after = 3; bad_addr = LAST; poke_at = 40;
    run_job(1);

    cmp_on = 0;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule